// File: doc/BRIEF.md
# Pixel Output Converter

This block turns the signed results of an inverse DCT into pixel values that can be displayed. Each signed 10-bit input sample is first halved with a bit-exact rounding rule and clamped to a signed 8-bit sample. In monochrome mode the clamped luma sample is sent out on all three channels. In colour mode one luma sample is combined with one blue-difference and one red-difference sample through four fixed-point coefficients with 12 fractional bits. The result is red, green and blue, each saturated to 8 bits.

At the end, an optional step turns the signed result into an unsigned pixel by adding 128. One sample set is accepted in any cycle in which `in_valid` is high. The mode inputs are taken together with that sample set. The result appears on registered outputs two clock cycles later. Macroblock storage, chroma upsampling addressing and the transform itself are handled elsewhere.

Top module: `pixconv_out`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `out_valid` is low and `r_out`, `g_out` and `b_out` are all zero.
- R2: A sample set taken at a rising edge with `in_valid` high produces exactly one output with `out_valid` high, two rising edges later. Results come out in input order, and no output appears without an input.
- R3: Each 10-bit two's-complement input x is reduced to floor((x+1)/2), computed at 11 bits, so 0x1FF becomes +256 before clamping rather than wrapping into the sign.
- R4: The halved value is clamped to -128..+127. For example, 3 gives 2, -3 gives -1, -1 gives 0, -512 gives -128 and 511 gives 127.
- R5: With `color_en` low, all three channels carry the reduced luma sample Y, and `cb_in` and `cr_in` have no effect.
- R6: With `color_en` high, red is Y + floor(5744*Cr/4096), where Cb and Cr are the reduced chroma samples.
- R7: With `color_en` high, green is Y + floor(-1408*Cb/4096) + floor(-2928*Cr/4096). Each product is floored on its own.
- R8: With `color_en` high, blue is Y + floor(7264*Cb/4096).
- R9: Each colour channel sum is formed without overflow and then saturated to -128..+127.
- R10: With `unsigned_en` low, each channel is the 8-bit two's-complement result. With it high, the channel is the result plus 128, in the range 0..255.
- R11: `color_en` and `unsigned_en` apply only to the sample set taken in the same cycle, so modes can change from one sample to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample set present this cycle |
| color_en | input | 1 | 1: colour conversion, 0: monochrome |
| unsigned_en | input | 1 | 1: unsigned output with +128 offset |
| y_in | input | 10 | Luma transform result, two's complement |
| cb_in | input | 10 | Blue-difference transform result, two's complement |
| cr_in | input | 10 | Red-difference transform result, two's complement |
| out_valid | output | 1 | Output channels valid |
| r_out | output | 8 | Red channel, or luma in monochrome mode |
| g_out | output | 8 | Green channel, or luma in monochrome mode |
| b_out | output | 8 | Blue channel, or luma in monochrome mode |

## Verification
The hardest conditions to reach are the rounding edges of the halving step and the cases where a colour channel saturates only because of the coefficient terms. Uniform random 10-bit inputs rarely land exactly on 0x1FF, -512 or odd negative values near zero. They also rarely push a channel just past its limit from a luma value near the rail. The stimulus therefore mixes full-range random values with values drawn from a narrow band around the limits. Directed sample sets are added for the extreme luma and chroma combinations and for back-to-back mode changes. Random gaps in `in_valid` check that ordering and latency hold under an irregular stream.

// File: rtl/pixconv_pkg.sv
package pixconv_pkg;
  localparam int RAW_W  = 10;
  localparam int PIX_W  = 8;
  localparam int FRAC_W = 12;
  localparam int COEF_W = 14;
  localparam int NTERM  = 4;
  // term order: red<-Cr, green<-Cb, green<-Cr, blue<-Cb
  localparam int COEF_TAB [NTERM] = '{5744, -1408, -2928, 7264};
  localparam bit SRC_IS_CR [NTERM] = '{1'b1, 1'b0, 1'b1, 1'b0};
  localparam int TERM_W = PIX_W + COEF_W - FRAC_W;
  localparam int SUM_W  = TERM_W + 2;

  typedef struct packed {
    logic                    valid;
    logic                    color;
    logic                    unsgn;
    logic signed [PIX_W-1:0] y;
    logic signed [PIX_W-1:0] cb;
    logic signed [PIX_W-1:0] cr;
  } stage1_t;
endpackage

// File: rtl/pixconv_halve.sv
module pixconv_halve #(
  parameter int IN_W  = 10,
  parameter int OUT_W = 8
) (
  input  logic signed [IN_W-1:0]  raw,
  output logic signed [OUT_W-1:0] half
);
  localparam int SW = IN_W + 1;
  localparam logic signed [IN_W-1:0] HI = IN_W'((1 <<< (OUT_W-1)) - 1);
  localparam logic signed [IN_W-1:0] LO = IN_W'(-(1 <<< (OUT_W-1)));

  logic signed [SW-1:0]   bumped;
  logic signed [IN_W-1:0] shifted;

  always_comb begin
    bumped  = SW'(raw) + SW'(1);
    shifted = IN_W'(bumped >>> 1);
    if (shifted > HI)      half = OUT_W'(HI);
    else if (shifted < LO) half = OUT_W'(LO);
    else                   half = OUT_W'(shifted);
  end
endmodule

// File: rtl/pixconv_term.sv
module pixconv_term #(
  parameter int IN_W   = 8,
  parameter int COEF_W = 14,
  parameter int FRAC_W = 12,
  parameter int COEF   = 0
) (
  input  logic signed [IN_W-1:0]               chroma,
  output logic signed [IN_W+COEF_W-FRAC_W-1:0] term
);
  localparam int PW = IN_W + COEF_W;
  localparam int OW = PW - FRAC_W;
  localparam logic signed [COEF_W-1:0] K = COEF_W'(COEF);

  logic signed [PW-1:0] prod;

  always_comb begin
    prod = PW'(chroma) * PW'(K);
    term = OW'(prod >>> FRAC_W);
  end
endmodule

// File: rtl/pixconv_sat.sv
module pixconv_sat #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 8
) (
  input  logic signed [IN_W-1:0]  wide,
  output logic signed [OUT_W-1:0] narrow
);
  localparam logic signed [IN_W-1:0] HI = IN_W'((1 <<< (OUT_W-1)) - 1);
  localparam logic signed [IN_W-1:0] LO = IN_W'(-(1 <<< (OUT_W-1)));

  always_comb begin
    if (wide > HI)      narrow = OUT_W'(HI);
    else if (wide < LO) narrow = OUT_W'(LO);
    else                narrow = OUT_W'(wide);
  end
endmodule

// File: rtl/pixconv_out.sv
module pixconv_out
  import pixconv_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    color_en,
  input  logic                    unsigned_en,
  input  logic signed [RAW_W-1:0] y_in,
  input  logic signed [RAW_W-1:0] cb_in,
  input  logic signed [RAW_W-1:0] cr_in,
  output logic                    out_valid,
  output logic [PIX_W-1:0]        r_out,
  output logic [PIX_W-1:0]        g_out,
  output logic [PIX_W-1:0]        b_out
);
  // ---------------- stage 1: halve and clamp each component
  logic signed [RAW_W-1:0] raw_vec [3];
  logic signed [PIX_W-1:0] half_vec [3];

  assign raw_vec[0] = y_in;
  assign raw_vec[1] = cb_in;
  assign raw_vec[2] = cr_in;

  for (genvar c = 0; c < 3; c++) begin : g_halve
    pixconv_halve #(.IN_W(RAW_W), .OUT_W(PIX_W)) u_halve (
      .raw  (raw_vec[c]),
      .half (half_vec[c])
    );
  end

  stage1_t s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
    end else begin
      s1.valid <= in_valid;
      if (in_valid) begin
        s1.color <= color_en;
        s1.unsgn <= unsigned_en;
        s1.y     <= half_vec[0];
        s1.cb    <= half_vec[1];
        s1.cr    <= half_vec[2];
      end
    end
  end

  // ---------------- stage 2: colour matrix and saturation
  logic signed [TERM_W-1:0] term_vec [NTERM];

  for (genvar k = 0; k < NTERM; k++) begin : g_term
    pixconv_term #(
      .IN_W(PIX_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W), .COEF(COEF_TAB[k])
    ) u_term (
      .chroma (SRC_IS_CR[k] ? s1.cr : s1.cb),
      .term   (term_vec[k])
    );
  end

  logic signed [SUM_W-1:0] sum_r, sum_g, sum_b;
  logic signed [PIX_W-1:0] sat_r, sat_g, sat_b;

  always_comb begin
    sum_r = SUM_W'(s1.y) + SUM_W'(term_vec[0]);
    sum_g = SUM_W'(s1.y) + SUM_W'(term_vec[1]) + SUM_W'(term_vec[2]);
    sum_b = SUM_W'(s1.y) + SUM_W'(term_vec[3]);
  end

  pixconv_sat #(.IN_W(SUM_W), .OUT_W(PIX_W)) u_sat_r (.wide(sum_r), .narrow(sat_r));
  pixconv_sat #(.IN_W(SUM_W), .OUT_W(PIX_W)) u_sat_g (.wide(sum_g), .narrow(sat_g));
  pixconv_sat #(.IN_W(SUM_W), .OUT_W(PIX_W)) u_sat_b (.wide(sum_b), .narrow(sat_b));

  logic signed [PIX_W-1:0] r_s, g_s, b_s;
  logic                    unsgn2, color2;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      r_s       <= '0;
      g_s       <= '0;
      b_s       <= '0;
      unsgn2    <= 1'b0;
      color2    <= 1'b0;
    end else begin
      out_valid <= s1.valid;
      if (s1.valid) begin
        unsgn2 <= s1.unsgn;
        color2 <= s1.color;
        r_s    <= s1.color ? sat_r : s1.y;
        g_s    <= s1.color ? sat_g : s1.y;
        b_s    <= s1.color ? sat_b : s1.y;
      end
    end
  end

  // offset by 128 is an inversion of the top bit of a signed 8-bit value
  assign r_out = r_s ^ {unsgn2, {(PIX_W-1){1'b0}}};
  assign g_out = g_s ^ {unsgn2, {(PIX_W-1){1'b0}}};
  assign b_out = b_s ^ {unsgn2, {(PIX_W-1){1'b0}}};

  // ---------------- assertions
  a_r2_out_follows_in: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid, 2) |-> out_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));
  a_r3_top_rounds_high: assert property (@(posedge clk) disable iff (rst)
    (in_valid && y_in == 10'sh1FF) |=> (s1.y == 8'sd127));
  a_r4_nonneg_stays: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !y_in[RAW_W-1]) |=> (s1.y >= 0));
  a_r5_mono_equal: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !color2) |-> (r_out == g_out && g_out == b_out));
  a_r6_red_not_below: assert property (@(posedge clk) disable iff (rst)
    (s1.valid && s1.color && !s1.cr[PIX_W-1]) |=> (r_s >= $past(s1.y)));
  a_r7_green_not_above: assert property (@(posedge clk) disable iff (rst)
    (s1.valid && s1.color && !s1.cr[PIX_W-1] && !s1.cb[PIX_W-1]) |=> (g_s <= $past(s1.y)));
  a_r8_blue_not_below: assert property (@(posedge clk) disable iff (rst)
    (s1.valid && s1.color && !s1.cb[PIX_W-1]) |=> (b_s >= $past(s1.y)));
endmodule

// File: tb/tb_pixconv_out.sv
`timescale 1ns/1ps
module tb_pixconv_out;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, in_valid, color_en, unsigned_en;
  logic signed [9:0] y_in, cb_in, cr_in;
  logic out_valid;
  logic [7:0] r_out, g_out, b_out;

  pixconv_out dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .color_en(color_en),
    .unsigned_en(unsigned_en), .y_in(y_in), .cb_in(cb_in), .cr_in(cr_in),
    .out_valid(out_valid), .r_out(r_out), .g_out(g_out), .b_out(b_out)
  );

  localparam int MAXV = 4096;
  int n_chk = 0, n_fail = 0;
  int wr = 0, rd = 0, cyc = 0;
  logic [7:0] er [MAXV], eg [MAXV], eb [MAXV];
  int ecyc [MAXV];
  string etag [MAXV];
  bit running = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int clamp8(int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  function automatic int halve(int raw);
    int x;
    x = raw & 1023;
    if (x >= 512) x = x - 1024;
    return clamp8((x + 1) >>> 1);
  endfunction

  function automatic int fterm(int coef, int c);
    return (coef * c) >>> 12;
  endfunction

  function automatic logic [7:0] fmt(int v, bit uns);
    return uns ? 8'(v + 128) : 8'(v);
  endfunction

  task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(int y, int cb, int cr, bit col, bit uns, string tag);
    int yy, bb, rr;
    yy = halve(y); bb = halve(cb); rr = halve(cr);
    in_valid = 1; color_en = col; unsigned_en = uns;
    y_in = 10'(y); cb_in = 10'(cb); cr_in = 10'(cr);
    if (col) begin
      er[wr] = fmt(clamp8(yy + fterm(5744, rr)), uns);
      eg[wr] = fmt(clamp8(yy + fterm(-1408, bb) + fterm(-2928, rr)), uns);
      eb[wr] = fmt(clamp8(yy + fterm(7264, bb)), uns);
    end else begin
      er[wr] = fmt(yy, uns); eg[wr] = er[wr]; eb[wr] = er[wr];
    end
    ecyc[wr] = cyc + 2;
    etag[wr] = tag;
    wr++;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    in_valid = 0;
    y_in = 10'($urandom); cb_in = 10'($urandom); cr_in = 10'($urandom);
    color_en = 1'($urandom); unsigned_en = 1'($urandom);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (running && out_valid) begin
      if (rd >= wr) begin
        check("R2 spurious", 24'(out_valid), 24'h0);
      end else begin
        check({etag[rd], " R2 timing"}, 24'(cyc), 24'(ecyc[rd]));
        check(etag[rd], {r_out, g_out, b_out}, {er[rd], eg[rd], eb[rd]});
        rd++;
      end
    end
  end

  function automatic int pick();
    int m;
    m = $urandom_range(0, 3);
    if (m == 0) return $urandom_range(0, 20) - 10;
    if (m == 1) return 511 - $urandom_range(0, 6);
    if (m == 2) return -512 + $urandom_range(0, 6);
    return $urandom_range(0, 1023) - 512;
  endfunction

  initial begin
    #1000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    rst = 1; in_valid = 0; color_en = 0; unsigned_en = 0;
    y_in = '0; cb_in = '0; cr_in = '0;
    repeat (4) @(negedge clk);
    check("R1 reset", {7'd0, out_valid, r_out, g_out, b_out}, 32'd0);
    rst = 0;
    @(negedge clk);
    check("R1 after reset", {7'd0, out_valid, r_out, g_out, b_out}, 32'd0);
    running = 1;

    // R3/R4 halving corners in mono
    push(511, 0, 0, 0, 0, "R3 0x1FF");
    push(3, 0, 0, 0, 0, "R4 three");
    push(-3, 0, 0, 0, 0, "R4 minus three");
    push(-1, 0, 0, 0, 0, "R4 minus one");
    push(-512, 0, 0, 0, 0, "R4 min");
    push(254, 0, 0, 0, 0, "R4 254");
    push(-10, 0, 0, 0, 0, "R3 minus ten");
    // R5: chroma ignored in mono
    push(100, 511, -512, 0, 0, "R5 chroma ignored");
    push(100, -512, 511, 0, 0, "R5 chroma ignored b");
    // R6 R8 R7 and R9 saturation
    push(40, 0, 100, 1, 0, "R6 red");
    push(40, 100, 0, 1, 0, "R8 blue");
    push(40, -77, 91, 1, 0, "R7 green");
    push(511, 511, 511, 1, 0, "R9 sat high");
    push(-512, -512, -512, 1, 0, "R9 sat low");
    push(-512, 511, 511, 1, 0, "R9 mixed");
    // R10 unsigned offset
    push(-512, 0, 0, 0, 1, "R10 unsigned min");
    push(511, 0, 0, 0, 1, "R10 unsigned max");
    push(0, 200, -200, 1, 1, "R10 unsigned colour");
    // R11 back-to-back mode changes
    push(60, 300, -300, 1, 0, "R11 colour");
    push(60, 300, -300, 0, 1, "R11 mono unsigned");
    push(60, 300, -300, 1, 1, "R11 colour unsigned");
    push(60, 300, -300, 0, 0, "R11 mono signed");
    idle(3);

    for (int i = 0; i < 1500; i++) begin
      bit col, uns;
      col = 1'($urandom); uns = 1'($urandom);
      push(pick(), pick(), pick(), col, uns,
           col ? "R6 R7 R8 R9 random colour" : "R5 R10 random mono");
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(5);
    check("R2 count", 24'(rd), 24'(wr));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule